// File: doc/BRIEF.md
# Hit Binning and Road Readout Engine

This block holds the full-resolution detector hits of one event and hands them back per matched road. Hits arrive one per cycle, in any order, each tagged with a detector layer and a coarse superstrip number. Each hit is filed into a bin chosen by that pair. Every bin is a singly linked list threaded through a shared hit memory, so one busy bin can use any share of the memory.

After the pattern matcher reports a road number, the block reads a road table that software loads beforehand. For each layer the table gives a superstrip value and a don't-care mask. The block then visits every bin that the masked value covers and streams out all hits stored there. The output stream uses valid/ready flow control, and each word is tagged with the road, the layer and two end flags. A layer that has no hits for the road still produces one marker word, so the fitter always sees every layer. An end-of-event pulse empties all bins at once.

Top module: `hit_organizer`

## Requirements
- R1: A hit is accepted when `hit_valid` and `hit_ready` are both high at a clock edge. Hits may arrive in any order of layer and superstrip. For a road, every stored hit whose layer and superstrip fall in the road's covered bins appears exactly once on the output with its payload unchanged. Within a layer, bins are read in ascending superstrip order, and within one bin the most recently stored hit comes first.
- R2: A write on the table port with `cfg_we` high stores the superstrip value and mask for the entry selected by (`cfg_road`, `cfg_layer`). A later write to the same entry replaces the earlier one.
- R3: A mask bit of 1 marks that superstrip bit as don't-care. Readout for a layer covers every superstrip equal to the table value on all bits whose mask bit is 0.
- R4: A layer with no stored hit in any covered bin produces exactly one word with `out_empty`=1, `out_last_layer`=1 and `out_data`=0.
- R5: Layers are emitted in order 0 to NLAYER-1. The final word of each layer has `out_last_layer`=1 and no other word of that layer does. `out_last_road`=1 appears only on the final word of layer NLAYER-1.
- R6: While `out_valid` is high and `out_ready` is low, the output word and `out_valid` hold unchanged into the next cycle.
- R7: While the hit memory is not full and no end-of-event pulse is present, `hit_ready` is high. A hit can be stored on every cycle, which is faster than the required 8 hits per 16 cycles.
- R8: At most DEPTH hits are stored per event. Once DEPTH hits are held, `hit_ready` is low and further hits are refused.
- R9: A one-cycle `evt_end` pulse empties every bin and the hit count in that cycle. Hits stored before it are never read out afterwards.
- R10: `road_ready` is high only while no road is being read out. A road accepted with `road_valid` starts readout, and `road_ready` returns high once its last word has been issued.
- R11: After reset, `out_valid` is 0, `hit_ready` is 1 and `road_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit can be stored this cycle |
| hit_layer | input | clog2(NLAYER) | Detector layer of the hit |
| hit_ssid | input | SSID_W | Coarse superstrip of the hit |
| hit_data | input | PAY_W | Full-resolution hit payload |
| evt_end | input | 1 | End-of-event pulse, empties all bins |
| road_valid | input | 1 | Matched road offered |
| road_ready | output | 1 | Engine idle, road can be taken |
| road_id | input | clog2(NROAD) | Matched road number |
| cfg_we | input | 1 | Road table write enable |
| cfg_road | input | clog2(NROAD) | Road table entry road |
| cfg_layer | input | clog2(NLAYER) | Road table entry layer |
| cfg_ssid | input | SSID_W | Superstrip value to store |
| cfg_mask | input | SSID_W | Don't-care mask to store |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Fitter accepts the word |
| out_road | output | clog2(NROAD) | Road of the word |
| out_layer | output | clog2(NLAYER) | Layer of the word |
| out_data | output | PAY_W | Hit payload, zero on a marker |
| out_empty | output | 1 | Empty-layer marker |
| out_last_layer | output | 1 | Final word of this layer |
| out_last_road | output | 1 | Final word of this road |

## Verification
The hardest case to reach from the ports is a completely full hit memory read back through a fully don't-care road, where every bin of every layer is walked while the fitter stalls at random. The bench fills all slots with hits scattered over all layers and superstrips, offers a few more that must be refused, and then reads one road with an all-ones mask in every layer while `out_ready` follows a pseudo-random pattern. The same stalling readout is used on a mixed-mask road, so that a layer ends on a held word while the output is blocked.

// File: rtl/hod_pkg.sv
package hod_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/hod_lut.sv
// Road table: per (road, layer) a superstrip value and a don't-care mask.
module hod_lut #(
    parameter int NLAYER = 4,
    parameter int NROAD  = 64,
    parameter int SSID_W = 8
) (
    input  logic                      clk,
    input  logic                      cfg_we,
    input  logic [$clog2(NROAD)-1:0]  cfg_road,
    input  logic [$clog2(NLAYER)-1:0] cfg_layer,
    input  logic [SSID_W-1:0]         cfg_ssid,
    input  logic [SSID_W-1:0]         cfg_mask,
    input  logic [$clog2(NROAD)-1:0]  rd_road,
    input  logic [$clog2(NLAYER)-1:0] rd_layer,
    output logic [SSID_W-1:0]         rd_ssid,
    output logic [SSID_W-1:0]         rd_mask
);
    localparam int ROAD_W  = $clog2(NROAD);
    localparam int LAYER_W = $clog2(NLAYER);
    localparam int NENT    = 1 << (ROAD_W + LAYER_W);

    logic [SSID_W-1:0] ssid_m [NENT];
    logic [SSID_W-1:0] mask_m [NENT];

    always_ff @(posedge clk) begin
        if (cfg_we) begin
            ssid_m[{cfg_road, cfg_layer}] <= cfg_ssid;
            mask_m[{cfg_road, cfg_layer}] <= cfg_mask;
        end
    end

    assign rd_ssid = ssid_m[{rd_road, rd_layer}];
    assign rd_mask = mask_m[{rd_road, rd_layer}];
endmodule

// File: rtl/hod_bins.sv
// Bin storage: per-bin valid flag and head pointer, shared hit memory with links.
module hod_bins #(
    parameter int NLAYER = 4,
    parameter int SSID_W = 8,
    parameter int DEPTH  = 256,
    parameter int PAY_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NLAYER)-1:0]   wr_layer,
    input  logic [SSID_W-1:0]           wr_ssid,
    input  logic [PAY_W-1:0]            wr_data,
    input  logic                        clr,
    output logic [$clog2(DEPTH):0]      fill_cnt,
    output logic                        full,
    input  logic [$clog2(NLAYER)-1:0]   rd_layer,
    input  logic [SSID_W-1:0]           rd_ssid,
    output logic                        rd_valid,
    output logic [$clog2(DEPTH)-1:0]    rd_head,
    input  logic [$clog2(DEPTH)-1:0]    rd_ptr,
    output logic [PAY_W-1:0]            rd_data,
    output logic                        rd_has_next,
    output logic [$clog2(DEPTH)-1:0]    rd_next
);
    localparam int LAYER_W = $clog2(NLAYER);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int BIN_W   = LAYER_W + SSID_W;
    localparam int NBIN    = 1 << BIN_W;
    localparam int CNT_W   = PTR_W + 1;

    typedef struct packed {
        logic [NBIN-1:0]  valid;
        logic [CNT_W-1:0] cnt;
    } bin_st_t;

    bin_st_t bs_d, bs_q;

    logic [PTR_W-1:0] head_m [NBIN];
    logic [PAY_W-1:0] data_m [DEPTH];
    logic [PTR_W-1:0] link_m [DEPTH];
    logic             more_m [DEPTH];

    logic [BIN_W-1:0] wr_bin;
    logic [PTR_W-1:0] slot;

    assign wr_bin = {wr_layer, wr_ssid};
    assign slot   = bs_q.cnt[PTR_W-1:0];

    always_comb begin
        bs_d = bs_q;
        if (clr) begin
            bs_d.valid = '0;
            bs_d.cnt   = '0;
        end else if (wr_en) begin
            bs_d.valid[wr_bin] = 1'b1;
            bs_d.cnt           = bs_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    // New hit becomes the list head; it links to the previous head if any.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            data_m[slot]   <= wr_data;
            link_m[slot]   <= head_m[wr_bin];
            more_m[slot]   <= bs_q.valid[wr_bin];
            head_m[wr_bin] <= slot;
        end
    end

    assign fill_cnt    = bs_q.cnt;
    assign full        = (bs_q.cnt == CNT_W'(DEPTH));
    assign rd_valid    = bs_q.valid[{rd_layer, rd_ssid}];
    assign rd_head     = head_m[{rd_layer, rd_ssid}];
    assign rd_data     = data_m[rd_ptr];
    assign rd_has_next = more_m[rd_ptr];
    assign rd_next     = link_m[rd_ptr];
endmodule

// File: rtl/hod_walk.sv
// Readout walker: layers in order, covered bins ascending, list per bin,
// one held word so that the layer's final word can carry its end flag.
module hod_walk
    import hod_pkg::*;
#(
    parameter int NLAYER = 4,
    parameter int NROAD  = 64,
    parameter int SSID_W = 8,
    parameter int DEPTH  = 256,
    parameter int PAY_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        road_valid,
    input  logic [$clog2(NROAD)-1:0]    road_id,
    output logic                        road_ready,
    output logic [$clog2(NROAD)-1:0]    lut_road,
    output logic [$clog2(NLAYER)-1:0]   lut_layer,
    input  logic [SSID_W-1:0]           lut_ssid,
    input  logic [SSID_W-1:0]           lut_mask,
    output logic [$clog2(NLAYER)-1:0]   bin_layer,
    output logic [SSID_W-1:0]           bin_ssid,
    input  logic                        bin_valid,
    input  logic [$clog2(DEPTH)-1:0]    bin_head,
    output logic [$clog2(DEPTH)-1:0]    hit_ptr,
    input  logic [PAY_W-1:0]            hit_data,
    input  logic                        hit_has_next,
    input  logic [$clog2(DEPTH)-1:0]    hit_next,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [$clog2(NROAD)-1:0]    out_road,
    output logic [$clog2(NLAYER)-1:0]   out_layer,
    output logic [PAY_W-1:0]            out_data,
    output logic                        out_empty,
    output logic                        out_last_layer,
    output logic                        out_last_road
);
    localparam int ROAD_W  = $clog2(NROAD);
    localparam int LAYER_W = $clog2(NLAYER);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam logic [LAYER_W-1:0] LAST_L = LAYER_W'(NLAYER - 1);

    typedef struct packed {
        walk_state_e        st;
        logic [ROAD_W-1:0]  road;
        logic [LAYER_W-1:0] layer;
        logic [SSID_W-1:0]  base;
        logic [SSID_W-1:0]  mask;
        logic [SSID_W-1:0]  sub;
        logic               bins_done;
        logic               in_list;
        logic [PTR_W-1:0]   ptr;
        logic               pend_v;
        logic [PAY_W-1:0]   pend_data;
        logic               ob_v;
        logic [ROAD_W-1:0]  ob_road;
        logic [LAYER_W-1:0] ob_layer;
        logic [PAY_W-1:0]   ob_data;
        logic               ob_empty;
        logic               ob_last_layer;
        logic               ob_last_road;
    } walk_st_t;

    walk_st_t w_d, w_q;
    logic              ob_free;
    logic [SSID_W-1:0] sub_nx;

    always_comb begin
        w_d       = w_q;
        ob_free   = !w_q.ob_v || out_ready;
        lut_road  = w_q.road;
        lut_layer = w_q.layer + LAYER_W'(1);
        bin_layer = w_q.layer;
        bin_ssid  = (w_q.base & ~w_q.mask) | w_q.sub;
        // next subset of the mask bits, in ascending order
        sub_nx    = ((w_q.sub | ~w_q.mask) + SSID_W'(1)) & w_q.mask;
        if (w_q.ob_v && out_ready) w_d.ob_v = 1'b0;
        unique case (w_q.st)
            W_IDLE: begin
                lut_road  = road_id;
                lut_layer = '0;
                if (road_valid) begin
                    w_d.st        = W_RUN;
                    w_d.road      = road_id;
                    w_d.layer     = '0;
                    w_d.base      = lut_ssid;
                    w_d.mask      = lut_mask;
                    w_d.sub       = '0;
                    w_d.bins_done = 1'b0;
                    w_d.in_list   = 1'b0;
                    w_d.pend_v    = 1'b0;
                end
            end
            W_RUN: begin
                if (w_q.in_list) begin
                    if (!w_q.pend_v || ob_free) begin
                        if (w_q.pend_v) begin
                            w_d.ob_v          = 1'b1;
                            w_d.ob_road       = w_q.road;
                            w_d.ob_layer      = w_q.layer;
                            w_d.ob_data       = w_q.pend_data;
                            w_d.ob_empty      = 1'b0;
                            w_d.ob_last_layer = 1'b0;
                            w_d.ob_last_road  = 1'b0;
                        end
                        w_d.pend_v    = 1'b1;
                        w_d.pend_data = hit_data;
                        if (hit_has_next) w_d.ptr     = hit_next;
                        else              w_d.in_list = 1'b0;
                    end
                end else if (w_q.bins_done) begin
                    if (ob_free) begin
                        w_d.ob_v          = 1'b1;
                        w_d.ob_road       = w_q.road;
                        w_d.ob_layer      = w_q.layer;
                        w_d.ob_data       = w_q.pend_v ? w_q.pend_data : '0;
                        w_d.ob_empty      = !w_q.pend_v;
                        w_d.ob_last_layer = 1'b1;
                        w_d.ob_last_road  = (w_q.layer == LAST_L);
                        w_d.pend_v        = 1'b0;
                        if (w_q.layer == LAST_L) begin
                            w_d.st = W_IDLE;
                        end else begin
                            w_d.layer     = w_q.layer + LAYER_W'(1);
                            w_d.base      = lut_ssid;
                            w_d.mask      = lut_mask;
                            w_d.sub       = '0;
                            w_d.bins_done = 1'b0;
                        end
                    end
                end else begin
                    if (bin_valid) begin
                        w_d.in_list = 1'b1;
                        w_d.ptr     = bin_head;
                    end
                    if (w_q.sub == w_q.mask) w_d.bins_done = 1'b1;
                    else                     w_d.sub       = sub_nx;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign road_ready     = (w_q.st == W_IDLE);
    assign hit_ptr        = w_q.ptr;
    assign out_valid      = w_q.ob_v;
    assign out_road       = w_q.ob_road;
    assign out_layer      = w_q.ob_layer;
    assign out_data       = w_q.ob_data;
    assign out_empty      = w_q.ob_empty;
    assign out_last_layer = w_q.ob_last_layer;
    assign out_last_road  = w_q.ob_last_road;
endmodule

// File: rtl/hit_organizer.sv
module hit_organizer #(
    parameter int NLAYER = 4,
    parameter int NROAD  = 64,
    parameter int SSID_W = 8,
    parameter int DEPTH  = 256,
    parameter int PAY_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit_valid,
    output logic                      hit_ready,
    input  logic [$clog2(NLAYER)-1:0] hit_layer,
    input  logic [SSID_W-1:0]         hit_ssid,
    input  logic [PAY_W-1:0]          hit_data,
    input  logic                      evt_end,
    input  logic                      road_valid,
    output logic                      road_ready,
    input  logic [$clog2(NROAD)-1:0]  road_id,
    input  logic                      cfg_we,
    input  logic [$clog2(NROAD)-1:0]  cfg_road,
    input  logic [$clog2(NLAYER)-1:0] cfg_layer,
    input  logic [SSID_W-1:0]         cfg_ssid,
    input  logic [SSID_W-1:0]         cfg_mask,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [$clog2(NROAD)-1:0]  out_road,
    output logic [$clog2(NLAYER)-1:0] out_layer,
    output logic [PAY_W-1:0]          out_data,
    output logic                      out_empty,
    output logic                      out_last_layer,
    output logic                      out_last_road
);
    localparam int ROAD_W  = $clog2(NROAD);
    localparam int LAYER_W = $clog2(NLAYER);
    localparam int PTR_W   = $clog2(DEPTH);

    logic [ROAD_W-1:0]  lut_road;
    logic [LAYER_W-1:0] lut_layer;
    logic [SSID_W-1:0]  lut_ssid, lut_mask;
    logic [LAYER_W-1:0] bin_layer;
    logic [SSID_W-1:0]  bin_ssid;
    logic               bin_valid;
    logic [PTR_W-1:0]   bin_head, hit_ptr, hit_next;
    logic [PAY_W-1:0]   mem_data;
    logic               hit_has_next;
    logic [PTR_W:0]     fill_cnt;
    logic               full;
    logic               hit_take;

    assign hit_ready = !full && !evt_end;
    assign hit_take  = hit_valid && hit_ready;

    hod_lut #(.NLAYER(NLAYER), .NROAD(NROAD), .SSID_W(SSID_W)) u_lut (
        .clk(clk), .cfg_we(cfg_we), .cfg_road(cfg_road), .cfg_layer(cfg_layer),
        .cfg_ssid(cfg_ssid), .cfg_mask(cfg_mask),
        .rd_road(lut_road), .rd_layer(lut_layer), .rd_ssid(lut_ssid), .rd_mask(lut_mask)
    );

    hod_bins #(.NLAYER(NLAYER), .SSID_W(SSID_W), .DEPTH(DEPTH), .PAY_W(PAY_W)) u_bins (
        .clk(clk), .rst_n(rst_n), .wr_en(hit_take), .wr_layer(hit_layer),
        .wr_ssid(hit_ssid), .wr_data(hit_data), .clr(evt_end),
        .fill_cnt(fill_cnt), .full(full),
        .rd_layer(bin_layer), .rd_ssid(bin_ssid), .rd_valid(bin_valid), .rd_head(bin_head),
        .rd_ptr(hit_ptr), .rd_data(mem_data), .rd_has_next(hit_has_next), .rd_next(hit_next)
    );

    hod_walk #(.NLAYER(NLAYER), .NROAD(NROAD), .SSID_W(SSID_W), .DEPTH(DEPTH), .PAY_W(PAY_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .road_valid(road_valid), .road_id(road_id),
        .road_ready(road_ready), .lut_road(lut_road), .lut_layer(lut_layer),
        .lut_ssid(lut_ssid), .lut_mask(lut_mask), .bin_layer(bin_layer), .bin_ssid(bin_ssid),
        .bin_valid(bin_valid), .bin_head(bin_head), .hit_ptr(hit_ptr), .hit_data(mem_data),
        .hit_has_next(hit_has_next), .hit_next(hit_next), .out_ready(out_ready),
        .out_valid(out_valid), .out_road(out_road), .out_layer(out_layer),
        .out_data(out_data), .out_empty(out_empty), .out_last_layer(out_last_layer),
        .out_last_road(out_last_road)
    );
endmodule

// File: rtl/hod_checker.sv
module hod_checker #(
    parameter int NLAYER = 4,
    parameter int NROAD  = 64,
    parameter int DEPTH  = 256,
    parameter int PAY_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hit_valid,
    input logic                      hit_ready,
    input logic                      evt_end,
    input logic                      road_valid,
    input logic                      road_ready,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [$clog2(NROAD)-1:0]  out_road,
    input logic [$clog2(NLAYER)-1:0] out_layer,
    input logic [PAY_W-1:0]          out_data,
    input logic                      out_empty,
    input logic                      out_last_layer,
    input logic                      out_last_road,
    input logic [$clog2(DEPTH):0]    fill_cnt
);
    localparam int CNT_W   = $clog2(DEPTH) + 1;
    localparam int LAYER_W = $clog2(NLAYER);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && hit_ready |=> fill_cnt == $past(fill_cnt) + CNT_W'(1));

    p_marker_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_last_layer && out_data == '0);

    p_road_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last_road |-> out_last_layer && out_layer == LAYER_W'(NLAYER - 1));

    p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_road)
            && $stable(out_layer) && $stable(out_empty) && $stable(out_last_layer)
            && $stable(out_last_road));

    p_accept_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt < CNT_W'(DEPTH) && !evt_end |-> hit_ready);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH) && (fill_cnt == CNT_W'(DEPTH) -> !hit_ready));

    p_event_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> fill_cnt == '0);

    p_road_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid && road_ready |=> !road_ready);
endmodule

bind hit_organizer hod_checker #(.NLAYER(NLAYER), .NROAD(NROAD), .DEPTH(DEPTH), .PAY_W(PAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .evt_end(evt_end), .road_valid(road_valid), .road_ready(road_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_road(out_road),
    .out_layer(out_layer), .out_data(out_data), .out_empty(out_empty),
    .out_last_layer(out_last_layer), .out_last_road(out_last_road), .fill_cnt(fill_cnt)
);

// File: tb/hit_organizer_bench.sv
module hit_organizer_bench;
    localparam int NL = 4, NR = 64, SW = 8, DEP = 256, PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          hit_valid = 0, evt_end = 0, road_valid = 0, cfg_we = 0, out_ready = 1;
    logic [1:0]    hit_layer = 0, cfg_layer = 0;
    logic [SW-1:0] hit_ssid = 0, cfg_ssid = 0, cfg_mask = 0;
    logic [PW-1:0] hit_data = 0;
    logic [5:0]    road_id = 0, cfg_road = 0;
    logic          hit_ready, road_ready, out_valid, out_empty, out_last_layer, out_last_road;
    logic [5:0]    out_road;
    logic [1:0]    out_layer;
    logic [PW-1:0] out_data;

    hit_organizer #(.NLAYER(NL), .NROAD(NR), .SSID_W(SW), .DEPTH(DEP), .PAY_W(PW)) u_hit_organizer (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_layer(hit_layer), .hit_ssid(hit_ssid), .hit_data(hit_data), .evt_end(evt_end),
        .road_valid(road_valid), .road_ready(road_ready), .road_id(road_id),
        .cfg_we(cfg_we), .cfg_road(cfg_road), .cfg_layer(cfg_layer), .cfg_ssid(cfg_ssid),
        .cfg_mask(cfg_mask), .out_valid(out_valid), .out_ready(out_ready),
        .out_road(out_road), .out_layer(out_layer), .out_data(out_data),
        .out_empty(out_empty), .out_last_layer(out_last_layer), .out_last_road(out_last_road)
    );

    typedef struct packed {
        logic [5:0]    road;
        logic [1:0]    layer;
        logic [PW-1:0] data;
        logic          empty;
        logic          ll;
        logic          lr;
    } wrd_t;

    int checks = 0, fails = 0;
    bit finished = 0;
    wrd_t exp_q[$];
    int nh = 0;
    logic [1:0]    h_lay [DEP];
    logic [SW-1:0] h_ss  [DEP];
    logic [PW-1:0] h_dat [DEP];
    logic [SW-1:0] m_ss [NR][NL];
    logic [SW-1:0] m_mk [NR][NL];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic wrd_t dut_word();
        return {out_road, out_layer, out_data, out_empty, out_last_layer, out_last_road};
    endfunction

    task automatic cfg(input int r, input int l, input int s, input int m);
        @(negedge clk);
        cfg_we = 1; cfg_road = 6'(r); cfg_layer = 2'(l); cfg_ssid = SW'(s); cfg_mask = SW'(m);
        m_ss[r][l] = SW'(s); m_mk[r][l] = SW'(m);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // One hit per call, back to back; returns whether it was taken.
    task automatic send_hit(input int l, input int s, input int d, output bit acc);
        @(negedge clk);
        hit_valid = 1; hit_layer = 2'(l); hit_ssid = SW'(s); hit_data = PW'(d);
        #1;
        acc = hit_ready;
        if (acc) begin
            h_lay[nh] = 2'(l); h_ss[nh] = SW'(s); h_dat[nh] = PW'(d); nh++;
        end
    endtask

    task automatic hits_off();
        @(negedge clk);
        hit_valid = 0;
    endtask

    task automatic pulse_eoe();
        @(negedge clk);
        evt_end = 1;
        @(negedge clk);
        evt_end = 0;
        nh = 0;
    endtask

    task automatic build_expect(input int r);
        exp_q.delete();
        for (int l = 0; l < NL; l++) begin
            int cnt = 0;
            for (int s = 0; s < (1 << SW); s++) begin
                if ((SW'(s) & ~m_mk[r][l]) == (m_ss[r][l] & ~m_mk[r][l])) begin
                    for (int i = nh - 1; i >= 0; i--) begin
                        if (h_lay[i] == 2'(l) && h_ss[i] == SW'(s)) begin
                            exp_q.push_back({6'(r), 2'(l), h_dat[i], 1'b0, 1'b0, 1'b0});
                            cnt++;
                        end
                    end
                end
            end
            if (cnt == 0) exp_q.push_back({6'(r), 2'(l), PW'(0), 1'b1, 1'b1, (l == NL - 1)});
            else begin
                exp_q[exp_q.size() - 1].ll = 1'b1;
                exp_q[exp_q.size() - 1].lr = (l == NL - 1);
            end
        end
    endtask

    task automatic run_road(input int r, input bit stall, input string req);
        int idx = 0, cyc = 0;
        bit held_v = 0;
        wrd_t held, w;
        build_expect(r);
        @(negedge clk);
        road_valid = 1; road_id = 6'(r);
        #1;
        chk(road_ready == 1'b1, "R10", "road_ready while idle", 64'(road_ready), 64'd1);
        @(negedge clk);
        road_valid = 0;
        while (idx < exp_q.size() && cyc < 20000) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall ? lfsr[0] : 1'b1;
            w = dut_word();
            if (out_valid && held_v)
                chk(w == held, "R6", "word held under stall", 64'(w), 64'(held));
            if (out_valid && out_ready) begin
                chk(w == exp_q[idx], req, $sformatf("word %0d of road %0d", idx, r),
                    64'(w), 64'(exp_q[idx]));
                idx++;
                held_v = 0;
            end else if (out_valid) begin
                held = w; held_v = 1;
            end else held_v = 0;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1;
        chk(idx == exp_q.size(), req, "word count", 64'(idx), 64'(exp_q.size()));
        chk(!out_valid && road_ready, "R10", "idle after road", {62'd0, out_valid, road_ready}, 64'd1);
    endtask

    task automatic t_reset();
        #1;
        chk(out_valid == 0 && hit_ready == 1 && road_ready == 1, "R11", "reset outputs",
            {61'd0, out_valid, hit_ready, road_ready}, 64'd3);
    endtask

    task automatic t_table();
        cfg(5, 1, 8'h99, 8'hFF);          // overwritten below (R2)
        cfg(5, 0, 8'h10, 0); cfg(5, 1, 8'h22, 0); cfg(5, 2, 8'h30, 0); cfg(5, 3, 8'h41, 0);
        cfg(9, 0, 8'h10, 8'h05); cfg(9, 1, 8'h20, 8'h03); cfg(9, 2, 8'h33, 0); cfg(9, 3, 8'h40, 8'h80);
        for (int l = 0; l < NL; l++) cfg(63, l, 8'h5A, 8'hFF);
    endtask

    task automatic t_basic();
        int acc_n = 0;
        bit a;
        pulse_eoe();
        send_hit(3, 8'h41, 16'h3001, a); acc_n += a;
        send_hit(0, 8'h10, 16'h0001, a); acc_n += a;
        send_hit(1, 8'h30, 16'h1BAD, a); acc_n += a;
        send_hit(0, 8'h11, 16'h0111, a); acc_n += a;
        send_hit(1, 8'h22, 16'h1001, a); acc_n += a;
        send_hit(0, 8'h10, 16'h0002, a); acc_n += a;
        send_hit(3, 8'h41, 16'h3002, a); acc_n += a;
        send_hit(0, 8'h10, 16'h0003, a); acc_n += a;
        hits_off();
        chk(acc_n == 8, "R7", "hits taken on consecutive cycles", 64'(acc_n), 64'd8);
        run_road(5, 0, "R1/R2/R4/R5");
    endtask

    task automatic t_ternary();
        bit a;
        send_hit(0, 8'h14, 16'h0140, a);
        send_hit(0, 8'h12, 16'h0120, a);
        send_hit(1, 8'h23, 16'h1230, a);
        send_hit(0, 8'h15, 16'h0150, a);
        send_hit(3, 8'hC0, 16'h3C00, a);
        send_hit(1, 8'h21, 16'h1210, a);
        send_hit(2, 8'h32, 16'h2320, a);
        hits_off();
        run_road(9, 0, "R3/R5");
        run_road(9, 1, "R3/R6");
    endtask

    task automatic t_clear();
        pulse_eoe();
        #1;
        chk(hit_ready == 1'b1, "R9", "hit_ready after event end", 64'(hit_ready), 64'd1);
        run_road(5, 0, "R9/R4");
    endtask

    task automatic t_capacity();
        int acc_n = 0;
        bit a;
        pulse_eoe();
        for (int i = 0; i < DEP + 4; i++) begin
            send_hit(i % NL, (i * 37) % (1 << SW), 16'h8000 + i, a);
            acc_n += a;
        end
        chk(hit_ready == 1'b0, "R8", "hit_ready low when full", 64'(hit_ready), 64'd0);
        hits_off();
        chk(acc_n == DEP, "R8", "hits stored at capacity", 64'(acc_n), 64'(DEP));
        run_road(63, 1, "R8/R3");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_table();
        t_basic();
        t_ternary();
        t_clear();
        t_capacity();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule